// File: doc/BRIEF.md
# Programmable Minimum-Width Input Qualifier

This block makes a single asynchronous input safe to use in clocked logic and removes short disturbances from it. The raw input first passes through a chain of flip-flops clocked by the system clock. The chain depth is a parameter from 2 to 8 stages. The synchronized level then goes to a width qualifier. The qualifier moves its output to a new level only after that level has stayed present for a programmed number of consecutive clock cycles.

The rejection width comes from an 8-bit value that software writes to a register. Glitch rejection can therefore be tuned while the chip runs, with no hardware change. A threshold of 0 or 1 turns the qualifier into a plain one-cycle follower. Every flip-flop in the block runs on the single clock. An active-low asynchronous reset clears all state.

Top module: `glitch_filter`

## Requirements
- R1: While `rst_n` is low, `clean_out` is 0. After reset is released with `raw_in` held at 0, `clean_out` stays 0.
- R2: With a threshold of 1, a level change on `raw_in` reaches `clean_out` exactly STAGES+1 clock edges after the first edge that samples it. With the default STAGES=3, that is 4 edges.
- R3: A pulse on `raw_in` that lasts one cycle fewer than the threshold never changes `clean_out`, at any point during or after the pulse.
- R4: A pulse that lasts exactly the threshold number of cycles T is passed. `clean_out` takes the new level STAGES+T edges after the pulse starts. It returns to the old level STAGES+T edges after the pulse ends.
- R5: A threshold of 0 behaves the same as a threshold of 1. A single-cycle pulse is passed with a latency of STAGES+1 edges.
- R6: A change of `min_width` does not disturb `clean_out`. The new value governs the next qualification.
- R7: The hold count restarts each time the synchronized level returns to the current output level. Two runs of T-2 cycles separated by a one-cycle gap are rejected.
- R8: Qualification is symmetric. While `clean_out` is 1, a low-going pulse shorter than the threshold is rejected and a low-going pulse of exactly the threshold is passed.
- R9: The largest threshold, 255, works: a 254-cycle pulse is rejected and a 255-cycle pulse is passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every flip-flop of the block uses it |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Unsynchronized input level to be cleaned |
| min_width | input | 8 | Minimum number of cycles a new level must hold to be accepted |
| clean_out | output | 1 | Synchronized, width-qualified level |

## Verification
The bench drives rising and falling pulses whose widths sit one cycle below and exactly at several thresholds (1, 4, 10, 255), and compares them against an expected output trace on every cycle. This separates an off-by-one in the width compare from an off-by-one in the synchronizer depth. A bouncing pattern shows whether the count restarts or accumulates. A threshold of 0 checks the follower case. A threshold change made while the output is high shows that retuning leaves the held level alone.

// File: rtl/gf_pkg.sv
package gf_pkg;

    localparam int unsigned GF_THR_W = 8;

    typedef logic [GF_THR_W-1:0] gf_thr_t;

    typedef struct packed {
        logic    level;
        gf_thr_t run;
    } gf_qual_t;

endpackage

// File: rtl/gf_sync_chain.sv
module gf_sync_chain #(
    parameter int unsigned STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    always_comb begin
        stage_d = {stage_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage_chk
            // R2
            stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                stage_q[gi] == $past(stage_q[gi-1]));
        end
    endgenerate

endmodule

// File: rtl/gf_width_qual.sv
module gf_width_qual
    import gf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sync_i,
    input  gf_thr_t thr_i,
    output logic    level_o
);

    localparam int unsigned SUM_W = GF_THR_W + 1;

    gf_qual_t st_d;
    gf_qual_t st_q;
    logic [SUM_W-1:0] sum_d;
    logic             pass_d;

    always_comb begin
        st_d   = st_q;
        sum_d  = {1'b0, st_q.run} + SUM_W'(1);
        pass_d = (thr_i <= gf_thr_t'(1)) || (sum_d >= {1'b0, thr_i});
        if (sync_i != st_q.level) begin
            if (pass_d) begin
                st_d.level = sync_i;
                st_d.run   = '0;
            end else begin
                st_d.run   = sum_d[GF_THR_W-1:0];
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;

    // R4
    flip_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.level) |->
            (($past(thr_i) <= gf_thr_t'(1)) ||
             (({1'b0, $past(st_q.run)} + SUM_W'(1)) >= {1'b0, $past(thr_i)})));

    // R3
    flip_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.level) |-> (st_q.level == $past(sync_i)));

    // R7
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_i) == $past(st_q.level)) |-> (st_q.run == '0));

    // R6
    run_below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(thr_i) && (thr_i > gf_thr_t'(1))) |-> (st_q.run < thr_i));

endmodule

// File: rtl/glitch_filter.sv
module glitch_filter #(
    parameter int unsigned STAGES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_in,
    input  logic [7:0] min_width,
    output logic       clean_out
);

    logic sync_lvl;

    gf_sync_chain #(
        .STAGES (STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_lvl)
    );

    gf_width_qual u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_lvl),
        .thr_i   (min_width),
        .level_o (clean_out)
    );

endmodule

// File: tb/glitch_filter_tb.sv
module glitch_filter_tb;

    localparam int S = 3;

    typedef struct {
        int    cyc;
        bit    val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_in = 1'b0;
    logic [7:0] min_width = 8'd1;
    logic       clean_out;

    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   lvl_m = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    glitch_filter #(.STAGES(S)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (raw_in),
        .min_width (min_width),
        .clean_out (clean_out)
    );

    function automatic void push(int c, bit v, string tag);
        exp_t e;
        e.cyc = c; e.val = v; e.tag = tag;
        sb.push_back(e);
    endfunction

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (e.cyc < cyc) begin
                n_fail++;
                $display("FAIL %s: stale entry cycle %0d at %0d (actual %b expected %b)",
                         e.tag, e.cyc, cyc, clean_out, e.val);
            end else if (clean_out !== e.val) begin
                n_fail++;
                $display("FAIL %s: cycle %0d actual %b expected %b", e.tag, cyc, clean_out, e.val);
            end
        end
    end

    task automatic direct(bit v, string tag);
        n_run++;
        if (clean_out !== v) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, clean_out, v);
        end
    endtask

    task automatic pulse(bit lvl, int w, int thr, string tag);
        int te;
        int c0;
        int c1;
        bit old;
        te  = (thr < 1) ? 1 : thr;
        old = lvl_m;
        @(negedge clk);
        c0 = cyc;
        raw_in = lvl;
        if (w >= te) begin
            for (int k = 1; k < S + te; k++) push(c0 + k, old, tag);
            push(c0 + S + te, lvl, tag);
        end else begin
            for (int k = 1; k <= S + w + te + 2; k++) push(c0 + k, old, tag);
        end
        repeat (w) @(negedge clk);
        raw_in = old;
        if (w >= te) begin
            c1 = cyc;
            push(c1 + S + te - 1, lvl, tag);
            push(c1 + S + te, old, tag);
        end
        repeat (S + te + 4) @(negedge clk);
    endtask

    task automatic set_level(bit lvl, int thr, string tag);
        int te;
        int c0;
        te = (thr < 1) ? 1 : thr;
        @(negedge clk);
        c0 = cyc;
        raw_in = lvl;
        push(c0 + S + te, lvl, tag);
        repeat (S + te + 3) @(negedge clk);
        lvl_m = lvl;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int c0;
        raw_in = 1'b1;
        repeat (3) @(negedge clk);
        direct(1'b0, "R1 during reset");
        raw_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        direct(1'b0, "R1 after release");

        min_width = 8'd1;
        pulse(1'b1, 1, 1, "R2 follow thr1");
        pulse(1'b1, 3, 1, "R2 follow thr1 w3");

        min_width = 8'd0;
        pulse(1'b1, 1, 0, "R5 thr0 single");

        min_width = 8'd4;
        pulse(1'b1, 3, 4, "R3 reject w3 thr4");
        pulse(1'b1, 4, 4, "R4 pass w4 thr4");

        min_width = 8'd10;
        pulse(1'b1, 9, 10, "R3 reject w9 thr10");
        pulse(1'b1, 10, 10, "R4 pass w10 thr10");

        // R7: bouncing input, count must restart after the gap
        min_width = 8'd6;
        @(negedge clk);
        c0 = cyc;
        for (int k = 1; k <= S + 20; k++) push(c0 + k, 1'b0, "R7 bounce");
        raw_in = 1'b1; repeat (4) @(negedge clk);
        raw_in = 1'b0; @(negedge clk);
        raw_in = 1'b1; repeat (4) @(negedge clk);
        raw_in = 1'b0;
        repeat (S + 14) @(negedge clk);

        // R8: hold output high, then falling pulses
        min_width = 8'd4;
        set_level(1'b1, 4, "R8 go high");
        pulse(1'b0, 3, 4, "R8 reject low w3");
        pulse(1'b0, 4, 4, "R8 pass low w4");

        // R6: retune while output is high
        @(negedge clk);
        c0 = cyc;
        min_width = 8'd10;
        for (int k = 1; k <= 5; k++) push(c0 + k, 1'b1, "R6 retune keeps level");
        repeat (6) @(negedge clk);
        pulse(1'b0, 9, 10, "R6 new thr reject low w9");
        pulse(1'b0, 10, 10, "R6 new thr pass low w10");
        min_width = 8'd4;
        set_level(1'b0, 4, "R6 back low");

        min_width = 8'd255;
        pulse(1'b1, 254, 255, "R9 reject w254");
        pulse(1'b1, 255, 255, "R9 pass w255");

        repeat (10) @(negedge clk);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule